// File: doc/BRIEF.md
# Video Port Output Formatter

This block is the last stage of a video decoder. It places decoded luminance and colour-difference samples, RGB samples, or raw converter samples onto a 16-bit video port. It runs on the line-locked clock, which is twice the pixel rate. It keeps its own horizontal counter and from it derives the horizontal reference. It also produces a clock qualifier whose meaning follows the selected format and qualifier mode. A vertical reference output repeats the incoming vertical window, either directly or four clocks later.

Four formats are supported. Three of them run at half the clock rate and hold each word for two clocks: 16-bit 4:2:2, 12-bit 4:1:1 and 16-bit RGB 5-6-5. The fourth is an 8-bit 4:2:2 stream at the full clock rate, carried on the upper byte. That stream has embedded timing codes before and after each active line.

Two further controls act on the port:
- A bypass can steer the raw samples of the two converters onto the two byte lanes. Each lane is gated by its own selection of the vertical window or its delayed copy.
- A data output enable, combined with a fast-enable input, decides whether the port drives.

Top module: `vport_fmt`

## Requirements
- R1: The horizontal counter runs from 0 to LINE_CLKS-1 and wraps. `href_o` is high for exactly 2*NPIX clocks (NPIX luminance samples) in every line, starting one clock after the counter reaches ACT_START. This happens whether or not `vwin_i` is high.
- R2: Format codes 0, 1 and 2 are the half-rate formats. In them the port word loads only on edges where the counter is even and holds through the odd clock. With qualifier mode 0, `cref_o` is high exactly in the first clock of each word, so it toggles every clock.
- R3: Format code 0 (16-bit 4:2:2), active region: bits 15:8 carry Y. Bits 7:0 carry Cb on even pixel indices and Cr on odd ones, where the pixel index is (counter-ACT_START)/2. Outside the active region the word is 16'h1080.
- R4: Format code 1 (12-bit 4:1:1), active region: bits 15:8 carry Y and bits 3:0 are zero. For group position k = pixel index mod 4, bits 7:6 carry bits (7-2k):(6-2k) of Cb and bits 5:4 carry the same bits of Cr. The chroma pair is taken at k=0 and held for k=1..3. Outside the active region the word is 16'h1080.
- R5: Format code 2 (RGB 5-6-5), active region: the word is {R[7:3], G[7:2], B[7:3]}, without limiting. Outside the active region it is zero.
- R6: Format code 3 (8-bit with embedded codes): the four clocks before the active region carry FF, 00, 00, XY on bits 15:8, and so do the first four clocks after it. XY = {1, F, V, H, V^H, F^H, F^V, F^V^H}, with F = `field_i`, V = not `vwin_i`, and H = 0 before the line and 1 after it.
- R7: Format code 3, active region with `vwin_i` high: bits 15:8 follow the order Cb, Y, Cr, Y for offsets 0..3 mod 4 from ACT_START. Every other clock outside the code words carries 80 on even counts and 10 on odd counts. Bits 7:0 are zero.
- R8: In format code 3, the internal qualifier is an inverted composite blanking signal: high exactly when the counter is in the active region and `vwin_i` is high.
- R9: `qual_sel_i` selects the qualifier: 0 gives the internal qualifier, 1 gives the internal qualifier ANDed with `vwin_i`, and 2 or 3 give a constant high.
- R10: With `byp_en_i` set, a lane whose select code is true loads the raw converter sample every clock. Converter 1 goes to bits 15:8 and converter 2 to bits 7:0. Select codes: 0 always, 1 while `vwin_i` is high, 2 while the 4-clock delayed window is high, 3 never.
- R11: `vref_o` follows `vwin_i` one clock later when `vref_dly_i` is 0, and five clocks later (four clocks of delay plus the output register) when it is 1.
- R12: In the Y, Cb and Cr formats every luminance and colour-difference sample is limited to the range 1 to 254. Input 0 is sent as 1 and input 255 as 254.
- R13: `vp_oe_o` is high one clock after `oe_data_i` is high and `fei_i` is low, and low otherwise. `sync_oe_o` follows `oe_sync_i` one clock later.
- R14: While `rst` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock (two clocks per pixel) |
| rst | input | 1 | Synchronous reset, active high |
| fmt_i | input | 2 | Format: 0 4:2:2, 1 4:1:1, 2 RGB 5-6-5, 3 8-bit embedded codes |
| qual_sel_i | input | 2 | Qualifier mode |
| byp_en_i | input | 1 | Enable raw converter bypass |
| byp_hi_sel_i | input | 2 | Bypass gating code for bits 15:8 |
| byp_lo_sel_i | input | 2 | Bypass gating code for bits 7:0 |
| vref_dly_i | input | 1 | Vertical reference from the delayed window |
| oe_data_i | input | 1 | Data output enable |
| oe_sync_i | input | 1 | Reference output enable |
| fei_i | input | 1 | Fast enable, high releases the port |
| vwin_i | input | 1 | Vertical active window from the decoder |
| field_i | input | 1 | Field identifier |
| y_i | input | 8 | Luminance sample |
| cb_i | input | 8 | Cb sample |
| cr_i | input | 8 | Cr sample |
| r_i | input | 8 | Red sample |
| g_i | input | 8 | Green sample |
| b_i | input | 8 | Blue sample |
| adc1_i | input | 8 | Raw sample, converter 1 |
| adc2_i | input | 8 | Raw sample, converter 2 |
| vp_data_o | output | 16 | Video port data |
| vp_oe_o | output | 1 | Video port drive enable |
| sync_oe_o | output | 1 | Reference outputs drive enable |
| cref_o | output | 1 | Clock or pixel qualifier |
| href_o | output | 1 | Horizontal reference |
| vref_o | output | 1 | Vertical reference |

## Verification
The bench checks the timing-code words at the line edges with explicit values. The protection bits in the XY byte are the main target: a design that swapped F and V in the protection bits would send an XY byte that no receiver accepts. It also checks the word hold on odd clocks after the bypass lane has been switched off. A design that got the hold wrong would let a raw sample leak into the next half-rate word, or would break the qualifier-to-data phase. The bench further probes the 4:1:1 chroma slicing across a group of four, the clamp at 0 and 255, the exact clock at which the delayed window reaches the vertical reference, and the fast-enable release. A wrong slice order, an off-by-one delay or an inverted enable each shows up as a single wrong word or bit at a known clock.

// File: rtl/vport_pkg.sv
package vport_pkg;

  typedef enum logic [1:0] {
    FMT_YUV422 = 2'd0,
    FMT_YUV411 = 2'd1,
    FMT_RGB565 = 2'd2,
    FMT_EMB8   = 2'd3
  } vport_fmt_e;

  // limit a Y/Cb/Cr sample to 1..254
  function automatic logic [7:0] lim_sample(input logic [7:0] x);
    if (x == 8'h00)      return 8'h01;
    else if (x == 8'hFF) return 8'hFE;
    else                 return x;
  endfunction

  // one byte of an embedded timing word; idx 0..3 within the code
  function automatic logic [7:0] code_byte(input logic [1:0] idx, input logic f,
                                           input logic v, input logic h);
    case (idx)
      2'd0:    return 8'hFF;
      2'd3:    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/vport_timing.sv
module vport_timing #(
  parameter int LINE_CLKS = 1716,
  parameter int ACT_START = 256,
  parameter int NPIX      = 720,
  localparam int HCW      = $clog2(LINE_CLKS)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [HCW-1:0] hcnt_o,
  output logic           act_o,
  output logic           href_o
);

  localparam int ACT_END = ACT_START + 2 * NPIX;

  logic [HCW-1:0] hcnt_q;
  logic           href_q;

  always_ff @(posedge clk) begin
    if (rst)                                  hcnt_q <= '0;
    else if (hcnt_q == HCW'(LINE_CLKS - 1))   hcnt_q <= '0;
    else                                      hcnt_q <= hcnt_q + 1'b1;
  end

  assign act_o  = (hcnt_q >= HCW'(ACT_START)) && (hcnt_q < HCW'(ACT_END));
  assign hcnt_o = hcnt_q;

  always_ff @(posedge clk) begin
    if (rst) href_q <= 1'b0;
    else     href_q <= act_o;
  end
  assign href_o = href_q;

  // checker: length of every high run of the horizontal reference
  logic [HCW:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (href_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R1
  href_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(href_q) |-> (run_q == (HCW+1)'(2 * NPIX)));

endmodule

// File: rtl/vport_bypass.sv
module vport_bypass #(
  parameter int DLY = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vwin_i,
  input  logic       byp_en_i,
  input  logic [1:0] sel_hi_i,
  input  logic [1:0] sel_lo_i,
  output logic       vwin_d_o,
  output logic       byp_hi_o,
  output logic       byp_lo_o
);

  logic [DLY-1:0] hist_q;

  generate
    if (DLY == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= vwin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[DLY-2:0], vwin_i};
      end
    end
  endgenerate

  assign vwin_d_o = hist_q[DLY-1];

  logic [1:0] sel   [2];
  logic [1:0] lane_on;
  assign sel[0] = sel_lo_i;
  assign sel[1] = sel_hi_i;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    always_comb begin
      case (sel[l])
        2'd0:    lane_on[l] = byp_en_i;
        2'd1:    lane_on[l] = byp_en_i & vwin_i;
        2'd2:    lane_on[l] = byp_en_i & hist_q[DLY-1];
        default: lane_on[l] = 1'b0;
      endcase
    end
  end

  assign byp_lo_o = lane_on[0];
  assign byp_hi_o = lane_on[1];

endmodule

// File: rtl/vport_pack.sv
module vport_pack
  import vport_pkg::*;
#(
  parameter int LINE_CLKS = 1716,
  parameter int ACT_START = 256,
  parameter int NPIX      = 720,
  localparam int HCW      = $clog2(LINE_CLKS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HCW-1:0] hcnt_i,
  input  logic           act_i,
  input  logic [1:0]     fmt_i,
  input  logic [1:0]     qual_sel_i,
  input  logic           vwin_i,
  input  logic           field_i,
  input  logic [7:0]     y_i,
  input  logic [7:0]     cb_i,
  input  logic [7:0]     cr_i,
  input  logic [7:0]     r_i,
  input  logic [7:0]     g_i,
  input  logic [7:0]     b_i,
  input  logic [7:0]     adc1_i,
  input  logic [7:0]     adc2_i,
  input  logic           byp_hi_i,
  input  logic           byp_lo_i,
  output logic [15:0]    data_o,
  output logic           cref_o
);

  localparam int ACT_END = ACT_START + 2 * NPIX;

  vport_fmt_e fmt;
  assign fmt = vport_fmt_e'(fmt_i);

  logic [HCW-1:0] ofs, sav_ofs, eav_ofs;
  logic           in_sav, in_eav;
  logic [1:0]     grp;
  logic [7:0]     yc, cbc, crc;
  logic [7:0]     cb_l_q, cr_l_q, cb_sh, cr_sh;
  logic [7:0]     hi_n, lo_n;
  logic           upd, qual_int, cref_n;

  assign ofs     = hcnt_i - HCW'(ACT_START);
  assign sav_ofs = hcnt_i - HCW'(ACT_START - 4);
  assign eav_ofs = hcnt_i - HCW'(ACT_END);
  assign in_sav  = (hcnt_i >= HCW'(ACT_START - 4)) && (hcnt_i < HCW'(ACT_START));
  assign in_eav  = (hcnt_i >= HCW'(ACT_END)) && (hcnt_i < HCW'(ACT_END + 4));
  assign grp     = ofs[2:1];

  assign yc  = lim_sample(y_i);
  assign cbc = lim_sample(cb_i);
  assign crc = lim_sample(cr_i);

  // 4:1:1 chroma pair taken at the first pixel of each group of four
  always_ff @(posedge clk) begin
    if (rst) begin
      cb_l_q <= '0;
      cr_l_q <= '0;
    end else if (act_i && !hcnt_i[0] && grp == 2'd0) begin
      cb_l_q <= cbc;
      cr_l_q <= crc;
    end
  end

  assign cb_sh = ((grp == 2'd0) ? cbc : cb_l_q) << {grp, 1'b0};
  assign cr_sh = ((grp == 2'd0) ? crc : cr_l_q) << {grp, 1'b0};

  always_comb begin
    hi_n = 8'h10;
    lo_n = 8'h80;
    case (fmt)
      FMT_YUV422: if (act_i) begin
        hi_n = yc;
        lo_n = ofs[1] ? crc : cbc;
      end
      FMT_YUV411: if (act_i) begin
        hi_n = yc;
        lo_n = {cb_sh[7:6], cr_sh[7:6], 4'b0000};
      end
      FMT_RGB565: begin
        hi_n = act_i ? {r_i[7:3], g_i[7:5]} : 8'h00;
        lo_n = act_i ? {g_i[4:2], b_i[7:3]} : 8'h00;
      end
      default: begin
        lo_n = 8'h00;
        if (in_sav)
          hi_n = code_byte(sav_ofs[1:0], field_i, ~vwin_i, 1'b0);
        else if (in_eav)
          hi_n = code_byte(eav_ofs[1:0], field_i, ~vwin_i, 1'b1);
        else if (act_i && vwin_i)
          case (ofs[1:0])
            2'd0:    hi_n = cbc;
            2'd2:    hi_n = crc;
            default: hi_n = yc;
          endcase
        else
          hi_n = hcnt_i[0] ? 8'h10 : 8'h80;
      end
    endcase
  end

  assign upd      = (fmt == FMT_EMB8) || !hcnt_i[0];
  assign qual_int = (fmt == FMT_EMB8) ? (act_i && vwin_i) : !hcnt_i[0];

  always_comb begin
    case (qual_sel_i)
      2'd0:    cref_n = qual_int;
      2'd1:    cref_n = qual_int & vwin_i;
      default: cref_n = 1'b1;
    endcase
  end

  logic [15:0] data_q;
  logic        cref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      cref_q <= 1'b0;
    end else begin
      if (byp_hi_i) data_q[15:8] <= adc1_i;
      else if (upd) data_q[15:8] <= hi_n;
      if (byp_lo_i) data_q[7:0]  <= adc2_i;
      else if (upd) data_q[7:0]  <= lo_n;
      cref_q <= cref_n;
    end
  end

  assign data_o = data_q;
  assign cref_o = cref_q;

  // R6
  xy_prot_chk: assert property (@(posedge clk) disable iff (rst)
    (fmt_i == 2'd3 && !byp_hi_i && in_eav && eav_ofs[1:0] == 2'd3)
    |=> (data_q[15:12] == {1'b1, $past(field_i), ~$past(vwin_i), 1'b1})
        && (data_q[11] == (data_q[13] ^ data_q[12]))
        && (data_q[8] == (data_q[14] ^ data_q[13] ^ data_q[12])));

endmodule

// File: rtl/vport_fmt.sv
module vport_fmt #(
  parameter int LINE_CLKS = 1716,
  parameter int ACT_START = 256,
  parameter int NPIX      = 720,
  parameter int VDLY      = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  fmt_i,
  input  logic [1:0]  qual_sel_i,
  input  logic        byp_en_i,
  input  logic [1:0]  byp_hi_sel_i,
  input  logic [1:0]  byp_lo_sel_i,
  input  logic        vref_dly_i,
  input  logic        oe_data_i,
  input  logic        oe_sync_i,
  input  logic        fei_i,
  input  logic        vwin_i,
  input  logic        field_i,
  input  logic [7:0]  y_i,
  input  logic [7:0]  cb_i,
  input  logic [7:0]  cr_i,
  input  logic [7:0]  r_i,
  input  logic [7:0]  g_i,
  input  logic [7:0]  b_i,
  input  logic [7:0]  adc1_i,
  input  logic [7:0]  adc2_i,
  output logic [15:0] vp_data_o,
  output logic        vp_oe_o,
  output logic        sync_oe_o,
  output logic        cref_o,
  output logic        href_o,
  output logic        vref_o
);

  localparam int HCW = $clog2(LINE_CLKS);

  logic [HCW-1:0] hcnt;
  logic           act, vwin_d, byp_hi, byp_lo;

  vport_timing #(.LINE_CLKS(LINE_CLKS), .ACT_START(ACT_START), .NPIX(NPIX)) u_timing (
    .clk(clk), .rst(rst), .hcnt_o(hcnt), .act_o(act), .href_o(href_o)
  );

  vport_bypass #(.DLY(VDLY)) u_bypass (
    .clk(clk), .rst(rst), .vwin_i(vwin_i), .byp_en_i(byp_en_i),
    .sel_hi_i(byp_hi_sel_i), .sel_lo_i(byp_lo_sel_i),
    .vwin_d_o(vwin_d), .byp_hi_o(byp_hi), .byp_lo_o(byp_lo)
  );

  vport_pack #(.LINE_CLKS(LINE_CLKS), .ACT_START(ACT_START), .NPIX(NPIX)) u_pack (
    .clk(clk), .rst(rst), .hcnt_i(hcnt), .act_i(act), .fmt_i(fmt_i),
    .qual_sel_i(qual_sel_i), .vwin_i(vwin_i), .field_i(field_i),
    .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i), .r_i(r_i), .g_i(g_i), .b_i(b_i),
    .adc1_i(adc1_i), .adc2_i(adc2_i), .byp_hi_i(byp_hi), .byp_lo_i(byp_lo),
    .data_o(vp_data_o), .cref_o(cref_o)
  );

  logic vref_q, oe_q, soe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vref_q <= 1'b0;
      oe_q   <= 1'b0;
      soe_q  <= 1'b0;
    end else begin
      vref_q <= vref_dly_i ? vwin_d : vwin_i;
      oe_q   <= oe_data_i & ~fei_i;
      soe_q  <= oe_sync_i;
    end
  end

  assign vref_o    = vref_q;
  assign vp_oe_o   = oe_q;
  assign sync_oe_o = soe_q;

  // R13
  fei_release_chk: assert property (@(posedge clk) disable iff (rst)
    (oe_data_i && fei_i) |=> !vp_oe_o);

  // R12
  sample_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (fmt_i == 2'd0 && !byp_en_i && !hcnt[0])
    |=> (vp_data_o[15:8] != 8'h00) && (vp_data_o[15:8] != 8'hFF)
        && (vp_data_o[7:0] != 8'h00) && (vp_data_o[7:0] != 8'hFF));

  // R2
  qual_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (qual_sel_i == 2'd0 && fmt_i != 2'd3 && $stable(qual_sel_i) && $stable(fmt_i))
    |=> (cref_o != $past(cref_o)));

  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fmt_i != 2'd3 && !byp_en_i && hcnt[0]) |=> $stable(vp_data_o));

endmodule

// File: tb/vport_fmt_tb.sv
module vport_fmt_tb;

  localparam int LINE = 48;
  localparam int HS   = 8;
  localparam int NP   = 12;
  localparam int HE   = HS + 2 * NP;
  localparam int NCFG = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt = 2'd0, qsel = 2'd0, lhi = 2'd3, llo = 2'd3;
  logic        byp = 1'b0, vsel = 1'b0, oed = 1'b0, oes = 1'b0, fei = 1'b0;
  logic        vwin = 1'b0, field = 1'b0;
  logic [7:0]  y = 0, cb = 0, cr = 0, r = 0, g = 0, b = 0, a1 = 0, a2 = 0;
  logic [15:0] vp_data;
  logic        vp_oe, sync_oe, cref, href, vref;

  int n_chk = 0, n_bad = 0, n = 0;

  always #10 clk = ~clk;

  vport_fmt #(.LINE_CLKS(LINE), .ACT_START(HS), .NPIX(NP), .VDLY(4)) u_dut (
    .clk(clk), .rst(rst), .fmt_i(fmt), .qual_sel_i(qsel), .byp_en_i(byp),
    .byp_hi_sel_i(lhi), .byp_lo_sel_i(llo), .vref_dly_i(vsel),
    .oe_data_i(oed), .oe_sync_i(oes), .fei_i(fei), .vwin_i(vwin), .field_i(field),
    .y_i(y), .cb_i(cb), .cr_i(cr), .r_i(r), .g_i(g), .b_i(b),
    .adc1_i(a1), .adc2_i(a2), .vp_data_o(vp_data), .vp_oe_o(vp_oe),
    .sync_oe_o(sync_oe), .cref_o(cref), .href_o(href), .vref_o(vref)
  );

  // configuration vectors: {fmt, qsel, byp, lhi, llo, vsel, oed, fei, oes}
  localparam logic [12:0] CFG [NCFG] = '{
    {2'd0, 2'd0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd1, 2'd0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd2, 2'd1, 1'b0, 2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd3, 2'd0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd3, 2'd2, 1'b0, 2'd3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd0, 2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd0, 2'd1, 1'b1, 2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd1, 2'd3, 1'b1, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'd0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'd2, 2'd0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd3, 2'd0, 1'b1, 2'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  function automatic logic [7:0] clp(input logic [7:0] x);
    return (x == 8'h00) ? 8'h01 : (x == 8'hFF) ? 8'hFE : x;
  endfunction

  function automatic logic [7:0] xyb(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic lane_on(input logic [1:0] s, input logic vw, input logic vd);
    return byp && ((s == 2'd0) || (s == 2'd1 && vw) || (s == 2'd2 && vd));
  endfunction

  // reference model, built from the requirements
  logic [15:0] ex_data;
  logic        ex_cref, ex_href, ex_vref, ex_oe, ex_soe;
  logic [3:0]  vh;
  logic [7:0]  cbl, crl;
  int          th;

  always @(posedge clk) begin : ref_model
    logic       act, bh, bl, upd, qi;
    logic [7:0] hi, lo, cs, rs;
    int         o, k, idx;
    if (rst) begin
      ex_data <= '0; ex_cref <= 0; ex_href <= 0; ex_vref <= 0; ex_oe <= 0; ex_soe <= 0;
      vh <= '0; cbl <= '0; crl <= '0; th <= 0;
    end else begin
      act = (th >= HS) && (th < HE);
      o   = th - HS;
      k   = (o / 2) % 4;
      hi  = 8'h10; lo = 8'h80;
      case (fmt)
        2'd0: if (act) begin hi = clp(y); lo = ((o / 2) % 2 == 1) ? clp(cr) : clp(cb); end
        2'd1: if (act) begin
          cs = (k == 0) ? clp(cb) : cbl;
          rs = (k == 0) ? clp(cr) : crl;
          hi = clp(y);
          lo = {cs[7-2*k -: 2], rs[7-2*k -: 2], 4'b0000};
        end
        2'd2: begin
          hi = act ? {r[7:3], g[7:5]} : 8'h00;
          lo = act ? {g[4:2], b[7:3]} : 8'h00;
        end
        default: begin
          lo = 8'h00;
          if (th >= HS - 4 && th < HS) begin
            idx = th - (HS - 4);
            hi = (idx == 0) ? 8'hFF : (idx == 3) ? xyb(field, ~vwin, 1'b0) : 8'h00;
          end else if (th >= HE && th < HE + 4) begin
            idx = th - HE;
            hi = (idx == 0) ? 8'hFF : (idx == 3) ? xyb(field, ~vwin, 1'b1) : 8'h00;
          end else if (act && vwin) begin
            hi = (o % 4 == 0) ? clp(cb) : (o % 4 == 2) ? clp(cr) : clp(y);
          end else begin
            hi = (th % 2 == 1) ? 8'h10 : 8'h80;
          end
        end
      endcase
      if (act && (th % 2 == 0) && k == 0) begin cbl <= clp(cb); crl <= clp(cr); end
      upd = (fmt == 2'd3) || (th % 2 == 0);
      bh  = lane_on(lhi, vwin, vh[3]);
      bl  = lane_on(llo, vwin, vh[3]);
      ex_data[15:8] <= bh ? a1 : (upd ? hi : ex_data[15:8]);
      ex_data[7:0]  <= bl ? a2 : (upd ? lo : ex_data[7:0]);
      qi = (fmt == 2'd3) ? (act && vwin) : (th % 2 == 0);
      ex_cref <= (qsel == 2'd0) ? qi : (qsel == 2'd1) ? (qi & vwin) : 1'b1;
      ex_href <= act;
      ex_vref <= vsel ? vh[3] : vwin;
      ex_oe   <= oed & ~fei;
      ex_soe  <= oes;
      vh      <= {vh[2:0], vwin};
      th      <= (th == LINE - 1) ? 0 : th + 1;
    end
  end

  task automatic chk(input string req, input logic [15:0] act_v, input logic [15:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (t=%0t)", req, act_v, exp_v, $time);
    end
  endtask

  function automatic string data_tag();
    if (byp) return "R10";
    case (fmt)
      2'd0:    return "R3";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic compare_all();
    chk(data_tag(), vp_data, ex_data);
    chk((fmt == 2'd3 && qsel == 2'd0) ? "R8" : "R9", {15'd0, cref}, {15'd0, ex_cref});
    chk("R1",  {15'd0, href},    {15'd0, ex_href});
    chk("R11", {15'd0, vref},    {15'd0, ex_vref});
    chk("R13", {15'd0, vp_oe},   {15'd0, ex_oe});
    chk("R13", {15'd0, sync_oe}, {15'd0, ex_soe});
  endtask

  task automatic pattern();
    y  = 8'(n * 37);      cb = 8'(n * 53 + 1);  cr = 8'(n * 11 + 200);
    r  = 8'(n * 7 + 3);   g  = 8'(n * 29);      b  = 8'(n * 13 + 90);
    a1 = 8'(n * 3);       a2 = ~8'(n);
    vwin  = ((n / 29) % 3) != 0;
    field = ((n / LINE) % 2) == 1;
    n++;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_cfg(input logic [12:0] c);
    {fmt, qsel, byp, lhi, llo, vsel, oed, fei, oes} = c;
  endtask

  task automatic run_to(input int h);
    while (th != h) tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R14: outputs are zero while reset is held
    chk("R14", vp_data, 16'h0000);
    chk("R14", {11'd0, vp_oe, sync_oe, cref, href, vref}, 16'h0000);
    rst = 1'b0;

    // vector table walk, two lines per configuration
    for (int i = 0; i < NCFG; i++) begin
      set_cfg(CFG[i]);
      for (int c = 0; c < 2 * LINE; c++) begin
        pattern();
        tick();
      end
    end

    // R6: embedded codes before the line, field 1, vertical blanking
    set_cfg({2'd3, 2'd0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1});
    field = 1'b1; vwin = 1'b0;
    run_to(HS - 4);
    tick(); chk("R6", {8'd0, vp_data[15:8]}, 16'h00FF);
    tick(); chk("R6", {8'd0, vp_data[15:8]}, 16'h0000);
    tick(); chk("R6", {8'd0, vp_data[15:8]}, 16'h0000);
    tick(); chk("R6", {8'd0, vp_data[15:8]}, 16'h00EC);

    // R8: qualifier rises with the first active clock when the window is open
    vwin = 1'b1;
    run_to(HS - 1);
    tick(); chk("R8", {15'd0, cref}, 16'h0000);
    tick(); chk("R8", {15'd0, cref}, 16'h0001);

    // R12: limits at 0 and 255 in 4:2:2
    set_cfg({2'd0, 2'd0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1});
    y = 8'h00; cb = 8'hFF; cr = 8'h00;
    run_to(HS);
    tick(); chk("R12", vp_data, 16'h01FE);
    // R2: second clock of the word holds it and drops the qualifier
    held = vp_data;
    chk("R2", {15'd0, cref}, 16'h0001);
    tick(); chk("R2", vp_data, held);
    chk("R2", {15'd0, cref}, 16'h0000);
    tick(); chk("R12", vp_data, 16'h0101);

    // R10: lane 1 raw sample, lane 2 decoder data
    set_cfg({2'd0, 2'd0, 1'b1, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1});
    a1 = 8'h00;
    tick(); chk("R10", {8'd0, vp_data[15:8]}, 16'h0000);

    // R11: delayed vertical reference reaches the pin five clocks after the window
    set_cfg({2'd0, 2'd0, 1'b0, 2'd3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1});
    vwin = 1'b0;
    repeat (6) tick();
    vwin = 1'b1;
    repeat (4) tick();
    chk("R11", {15'd0, vref}, 16'h0000);
    tick(); chk("R11", {15'd0, vref}, 16'h0001);

    // R13: fast enable releases the port and gives it back
    fei = 1'b1;
    tick(); chk("R13", {15'd0, vp_oe}, 16'h0000);
    fei = 1'b0;
    tick(); chk("R13", {15'd0, vp_oe}, 16'h0001);
    oed = 1'b0;
    tick(); chk("R13", {15'd0, vp_oe}, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule